// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and chooses which interrupt the core serves next. It accepts a reset request, a set of external interrupt lines and a set of internal request lines. The winning request produces a one-cycle take strobe, the number of the winning vector and the address of its slot in a vector table. The core uses the address to fetch the handler. Saving registers and handling the stack remain the core's job.

A global enable flag gates every source except the reset request. Each external line also has its own enable bit and a two-bit trigger code. External pins cross into the clock domain through a two-flop synchronizer. Edge-triggered lines latch a pending flag, and that flag is cleared when the line's vector is accepted. Level-triggered lines request for as long as the pin stays low.

Accepting any vector clears the global flag. The core restores the flag with a return pulse or an explicit set. A handler that sets the flag itself allows nesting. The table sits at address zero, or at a parameterised alternate base when the base-select input is high. Slots are four bytes apart.

Top module: `pvic_top`

## Requirements
- R1: After reset, take_o is 0, gie_o is 0, vec_num_o is 0 and vec_addr_o is 0.
- R2: Vector numbers are fixed: 0 is the reset request, 1 to N_EXT are external lines 0 to N_EXT-1, and N_EXT+1 onward are internal lines in index order. When several vectors are eligible in the same cycle, the lowest number is accepted.
- R3: An external line is accepted only while both gie_o and its ext_en_i bit are 1. An edge seen while the enable bit is 0 leaves no pending request behind.
- R4: An internal line requests while its int_irq_i bit is 1, and it is gated only by gie_o.
- R5: The trigger code of external line i is ext_mode_i[2i+1:2i]. The codes are 00 for low level, 01 for falling edge, 10 for rising edge and 11 for never.
- R6: An edge-triggered line stays pending until its vector is accepted, and then it does not request again without a new edge. A low-level line requests again after every acceptance for as long as its pin stays low.
- R7: Accepting a vector clears gie_o in the same edge. Otherwise gie_clr_i clears the flag, and gie_set_i or reti_i sets it. The clear command wins over set and return.
- R8: When gie_o is set again during service, a further higher-priority request is accepted, so nesting works.
- R9: A rising edge on rst_req_i is accepted as vector 0 even while gie_o is 0. Holding the request high does not produce a second acceptance.
- R10: vec_addr_o equals the table base plus 4 times vec_num_o. The base is 0 when base_sel_i is 0 and ALT_BASE (default 0x0400) when it is 1. base_sel_i is sampled in the acceptance cycle.
- R11: take_o is high for exactly one cycle for each acceptance. vec_num_o and vec_addr_o hold their value until the next acceptance, and at least one idle cycle separates two acceptances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq_i | input | N_EXT | Asynchronous external interrupt pins |
| ext_en_i | input | N_EXT | Per-line enable for the external pins |
| ext_mode_i | input | 2*N_EXT | Trigger code per external line |
| int_irq_i | input | N_INT | Internal request levels, active high |
| rst_req_i | input | 1 | Non-maskable reset request, taken on its rising edge |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable |
| reti_i | input | 1 | Return-from-interrupt pulse, sets the global enable |
| base_sel_i | input | 1 | Select the alternate table base |
| take_o | output | 1 | One-cycle acceptance strobe |
| vec_num_o | output | $clog2(1+N_EXT+N_INT) | Number of the accepted vector |
| vec_addr_o | output | ADDR_W | Vector slot address |
| gie_o | output | 1 | Global enable flag |

## Verification
A stale pending flag shows up as an extra take_o. It appears within four cycles after the global flag is set again, even though the line has not toggled. A lost pending flag shows up as a missing take after a valid edge. A wrong global-flag state shows up either as an acceptance while the flag should block, or as silence after a set or return pulse. Each of these is visible in the cycle after the pulse. Errors in priority and in base selection show up directly in vec_num_o and vec_addr_o during the strobe cycle.

// File: rtl/pvic_pkg.sv
// Shared types for the vectored interrupt controller.
// Assumes two-bit trigger codes per external line.
package pvic_pkg;
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_OFF  = 2'b11
    } trig_e;
endpackage

// File: rtl/pvic_ext_line.sv
// One external interrupt line: it synchronizes the pin, detects edges, latches
// a pending flag in edge modes and forms the request in every mode.
// Assumes the pin idles high, so the synchronizer resets to 1.
module pvic_ext_line
    import pvic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_i,
    input  logic  en_i,
    input  trig_e mode_i,
    input  logic  ack_i,
    output logic  req_o
);
    logic s1_q, s2_q, s3_q;
    logic pend_q;
    logic rise, fall, edge_hit, edge_mode;

    // two-flop synchronizer plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // decode the edge seen this cycle against the selected trigger
    always_comb begin
        rise      = s2_q & ~s3_q;
        fall      = ~s2_q & s3_q;
        edge_mode = (mode_i == TRIG_RISE) || (mode_i == TRIG_FALL);
        edge_hit  = ((mode_i == TRIG_RISE) & rise) | ((mode_i == TRIG_FALL) & fall);
    end

    // pending flag: set on edge, cleared on acceptance, dropped when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= en_i & edge_mode & ((pend_q & ~ack_i) | edge_hit);
        end
    end

    // request toward the arbiter
    always_comb begin
        req_o = en_i & (((mode_i == TRIG_LOW) & ~s2_q) | (edge_mode & pend_q));
    end
endmodule

// File: rtl/pvic_arbiter.sv
// Fixed-priority arbiter: the lowest index among the asserted requests wins.
// Assumes the requests are already masked.
module pvic_arbiter #(
    parameter int unsigned N   = 9,
    localparam int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req_i,
    output logic           valid_o,
    output logic [IDW-1:0] idx_o
);
    // scan from the top down so the lowest set index is kept last
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/pvic_gie.sv
// Global interrupt enable flag. Acceptance and clear take precedence over
// set and return. Assumes the command inputs are single-cycle pulses.
module pvic_gie (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic reti_i,
    input  logic accept_i,
    output logic gie_o
);
    // update the flag in precedence order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_o <= 1'b0;
        end else if (accept_i || clr_i) begin
            gie_o <= 1'b0;
        end else if (set_i || reti_i) begin
            gie_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pvic_top.sv
// Vectored interrupt controller top. It masks the sources, arbitrates by
// vector number and registers the take strobe, vector number and address.
// Assumes the core accepts take_o in the cycle it is high.
module pvic_top
    import pvic_pkg::*;
#(
    parameter int unsigned N_EXT  = 4,
    parameter int unsigned N_INT  = 4,
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] ALT_BASE = 'h0400,
    localparam int unsigned NVEC = 1 + N_EXT + N_INT,
    localparam int unsigned IDW  = $clog2(NVEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_EXT-1:0]   ext_irq_i,
    input  logic [N_EXT-1:0]   ext_en_i,
    input  logic [2*N_EXT-1:0] ext_mode_i,
    input  logic [N_INT-1:0]   int_irq_i,
    input  logic               rst_req_i,
    input  logic               gie_set_i,
    input  logic               gie_clr_i,
    input  logic               reti_i,
    input  logic               base_sel_i,
    output logic               take_o,
    output logic [IDW-1:0]     vec_num_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic               gie_o
);
    localparam int unsigned EXT_LO = 1;
    localparam int unsigned INT_LO = 1 + N_EXT;

    logic [N_EXT-1:0] ext_req;
    logic [NVEC-1:0]  masked_req;
    logic [NVEC-1:0]  ack_vec;
    logic             arb_valid, grant;
    logic [IDW-1:0]   arb_idx;
    logic             rst_req_q, rst_pend_q;
    logic [ADDR_W-1:0] base;

    // one synchronizer and trigger unit per external line
    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        pvic_ext_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_irq_i[g]),
            .en_i   (ext_en_i[g]),
            .mode_i (trig_e'(ext_mode_i[2*g +: 2])),
            .ack_i  (ack_vec[EXT_LO + g]),
            .req_o  (ext_req[g])
        );
    end

    // reset request: latch its rising edge until vector 0 is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q  <= 1'b0;
            rst_pend_q <= 1'b0;
        end else begin
            rst_req_q  <= rst_req_i;
            rst_pend_q <= (rst_pend_q & ~ack_vec[0]) | (rst_req_i & ~rst_req_q);
        end
    end

    // build the masked request vector in vector-number order
    always_comb begin
        masked_req = '0;
        masked_req[0] = rst_pend_q;
        for (int i = 0; i < N_EXT; i++) masked_req[EXT_LO + i] = ext_req[i] & gie_o;
        for (int j = 0; j < N_INT; j++) masked_req[INT_LO + j] = int_irq_i[j] & gie_o;
    end

    pvic_arbiter #(.N(NVEC)) u_arb (
        .req_i   (masked_req),
        .valid_o (arb_valid),
        .idx_o   (arb_idx)
    );

    // grant only outside a strobe cycle, so acceptances are separated by one idle cycle
    always_comb begin
        grant   = arb_valid & ~take_o;
        ack_vec = '0;
        if (grant) ack_vec[arb_idx] = 1'b1;
        base    = base_sel_i ? ALT_BASE : '0;
    end

    pvic_gie u_gie (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (gie_set_i),
        .clr_i    (gie_clr_i),
        .reti_i   (reti_i),
        .accept_i (grant),
        .gie_o    (gie_o)
    );

    // register the strobe and hold the vector outputs between acceptances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            vec_num_o  <= '0;
            vec_addr_o <= '0;
        end else begin
            take_o <= grant;
            if (grant) begin
                vec_num_o  <= arb_idx;
                vec_addr_o <= base + (ADDR_W'(arb_idx) << 2);
            end
        end
    end
endmodule

// File: rtl/pvic_checker.sv
// Property checker for pvic_top, attached by bind. It only observes the ports.
module pvic_checker #(
    parameter int unsigned N_EXT  = 4,
    parameter int unsigned N_INT  = 4,
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] ALT_BASE = 'h0400,
    localparam int unsigned NVEC = 1 + N_EXT + N_INT,
    localparam int unsigned IDW  = $clog2(NVEC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_EXT-1:0]  ext_en_i,
    input logic              gie_clr_i,
    input logic              reti_i,
    input logic              base_sel_i,
    input logic              take_o,
    input logic [IDW-1:0]    vec_num_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic              gie_o
);
    logic [N_EXT-1:0]  en_q;
    logic              sel_q;
    logic              is_ext, line_en;
    logic [ADDR_W-1:0] exp_addr;

    // remember the enables and the base select from the acceptance cycle
    always_ff @(posedge clk) begin
        en_q  <= ext_en_i;
        sel_q <= base_sel_i;
    end

    // expected address and enable of the line being strobed
    always_comb begin
        is_ext  = (vec_num_o >= IDW'(1)) && (vec_num_o <= IDW'(N_EXT));
        line_en = 1'b0;
        for (int i = 0; i < N_EXT; i++)
            if (vec_num_o == IDW'(i + 1)) line_en = en_q[i];
        exp_addr = (sel_q ? ALT_BASE : '0) + (ADDR_W'(vec_num_o) << 2);
    end

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
    a_r11_hold_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> $stable(vec_addr_o));
    a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !gie_o);
    a_r7_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reti_i) && !$past(gie_clr_i) && !take_o) |-> gie_o);
    a_r3_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_num_o != '0) |-> $past(gie_o));
    a_r3_needs_line_en: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && is_ext) |-> line_en);
    a_r10_address: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_addr_o == exp_addr));
endmodule

bind pvic_top pvic_checker #(
    .N_EXT(N_EXT), .N_INT(N_INT), .ADDR_W(ADDR_W), .ALT_BASE(ALT_BASE)
) u_chk (.*);

// File: tb/pvic_top_test.sv
// Directed bench for pvic_top: one task per scenario, each checking its own results.
module pvic_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_EXT = 4;
    localparam int N_INT = 4;
    localparam int ADDR_W = 16;
    localparam logic [15:0] ALT = 16'h0400;

    logic clk = 0;
    logic rst_n = 0;
    logic [N_EXT-1:0] ext_irq = '1;
    logic [N_EXT-1:0] ext_en = '0;
    logic [2*N_EXT-1:0] ext_mode = '1;
    logic [N_INT-1:0] int_irq = '0;
    logic rst_req = 0, gie_set = 0, gie_clr = 0, reti = 0, base_sel = 0;
    logic take;
    logic [3:0] vnum;
    logic [ADDR_W-1:0] vaddr;
    logic gie;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    pvic_top uut (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .ext_en_i(ext_en),
        .ext_mode_i(ext_mode), .int_irq_i(int_irq), .rst_req_i(rst_req),
        .gie_set_i(gie_set), .gie_clr_i(gie_clr), .reti_i(reti),
        .base_sel_i(base_sel), .take_o(take), .vec_num_o(vnum),
        .vec_addr_o(vaddr), .gie_o(gie)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: cycles %0d expected below 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_set();
        @(negedge clk); gie_set = 1; @(negedge clk); gie_set = 0;
    endtask
    task automatic pulse_clr();
        @(negedge clk); gie_clr = 1; @(negedge clk); gie_clr = 0;
    endtask
    task automatic pulse_reti();
        @(negedge clk); reti = 1; @(negedge clk); reti = 0;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // wait for a strobe and compare the vector number and address
    task automatic expect_take(input string req, input int num, input int addr, input int lim);
        bit got = 0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); #1;
            if (take) begin got = 1; break; end
        end
        check(got, req, got, 1);
        if (got) begin
            check(vnum == num, req, vnum, num);
            check(vaddr == addr, req, vaddr, addr);
            check(!gie, {req, " R7 gie cleared"}, gie, 0);
            @(posedge clk); #1;
            check(!take, {req, " R11 one cycle"}, take, 0);
            check(vnum == num, {req, " R11 hold"}, vnum, num);
        end
    endtask

    task automatic expect_none(input string req, input int lim);
        int seen = 0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); #1;
            if (take) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic t_reset();
        check(!take && !gie && vnum == 0 && vaddr == 0, "R1 reset state",
              {take, gie, vnum}, 0);
    endtask

    task automatic t_internal();
        @(negedge clk); int_irq[2] = 1;
        expect_none("R4 masked by gie", 8);
        pulse_set();
        expect_take("R4 internal line 2", 7, 28, 6);
        @(negedge clk); int_irq = '0;
    endtask

    task automatic t_priority();
        @(negedge clk);
        ext_mode[5:4] = 2'b00; ext_en[2] = 1; ext_irq[2] = 0;
        int_irq[0] = 1; int_irq[3] = 1;
        idle(4);
        pulse_set();
        expect_take("R2 lowest wins", 3, 12, 6);
        @(negedge clk); ext_irq[2] = 1;
        idle(4);
        pulse_reti();
        expect_take("R7 reti reenables, R2 next", 5, 20, 6);
        @(negedge clk); int_irq = '0; ext_en[2] = 0; ext_mode[5:4] = 2'b11;
    endtask

    task automatic t_disabled_rising();
        @(negedge clk); ext_mode[3:2] = 2'b10; ext_en[1] = 0; ext_irq[1] = 0;
        pulse_set();
        idle(3);
        @(negedge clk); ext_irq[1] = 1;
        expect_none("R3 disabled line", 8);
        @(negedge clk); ext_en[1] = 1;
        expect_none("R3 no leftover pending", 8);
        @(negedge clk); ext_irq[1] = 0;
        idle(3);
        @(negedge clk); ext_irq[1] = 1;
        expect_take("R5 rising edge line 1", 2, 8, 8);
        @(negedge clk); ext_en[1] = 0; ext_mode[3:2] = 2'b11;
    endtask

    task automatic t_falling_and_level();
        @(negedge clk); ext_mode[1:0] = 2'b01; ext_en[0] = 1;
        pulse_set();
        @(negedge clk); ext_irq[0] = 0;
        expect_take("R5 falling edge line 0", 1, 4, 8);
        pulse_set();
        expect_none("R6 edge pending cleared", 8);
        @(negedge clk); ext_mode[1:0] = 2'b00;
        pulse_set();
        expect_take("R6 level first", 1, 4, 6);
        pulse_set();
        expect_take("R6 level again", 1, 4, 6);
        @(negedge clk); ext_irq[0] = 1;
        idle(3);
        @(negedge clk); ext_en[0] = 0; ext_mode[1:0] = 2'b11;
    endtask

    task automatic t_mode_off();
        @(negedge clk); ext_mode[7:6] = 2'b11; ext_en[3] = 1;
        pulse_set();
        @(negedge clk); ext_irq[3] = 0;
        idle(3);
        @(negedge clk); ext_irq[3] = 1;
        expect_none("R5 code 11 never triggers", 8);
        @(negedge clk); ext_en[3] = 0;
        pulse_clr();
        check(!gie, "R7 clear", gie, 0);
    endtask

    task automatic t_reset_request();
        @(negedge clk); rst_req = 1;
        expect_take("R9 reset request while gie 0", 0, 0, 6);
        expect_none("R9 held request no repeat", 8);
        @(negedge clk); rst_req = 0;
    endtask

    task automatic t_alt_base_nesting();
        @(negedge clk); base_sel = 1; int_irq[1] = 1;
        pulse_set();
        expect_take("R10 alt base internal 1", 6, 16'h0400 + 24, 6);
        @(negedge clk); int_irq[0] = 1;
        pulse_set();
        expect_take("R8 nested higher priority", 5, 16'h0400 + 20, 6);
        @(negedge clk); int_irq = '0; base_sel = 0;
    endtask

    task automatic t_precedence();
        @(negedge clk); gie_set = 1; gie_clr = 1;
        @(negedge clk); gie_set = 0; gie_clr = 0;
        check(!gie, "R7 clear beats set", gie, 0);
        pulse_set();
        check(gie, "R7 set", gie, 1);
        pulse_clr();
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        #1;
        t_reset();
        t_internal();
        t_priority();
        t_disabled_rising();
        t_falling_and_level();
        t_mode_off();
        t_reset_request();
        t_alt_base_nesting();
        t_precedence();
        summary();
        $finish;
    end
endmodule